// File: doc/BRIEF.md
# Battery Over-Discharge Protection Controller

This block is the digital sequencer of a three-cell battery pack guard. Per-cell comparator flags tell it which cells sit below the over-discharge threshold and which have climbed back above the recovery threshold. When a cell stays low for a programmed delay, the block turns off both power FETs, latches a protection state and powers the device down into sleep. Serial access is cut during sleep.

A rising supply flag wakes the device. A hold-off window then runs, and host writes to the FET control bits are discarded until it ends. The block stays in protection until the cells recover. In monitor mode it runs a release timer that must expire with every cell still recovered. Otherwise it takes two recovery samples one interval apart, and both must agree. All delays are counted in ticks of a slow enable pulse, so each is a parameter.

A host writes a two-bit FET control register. While the block is protected, the discharge bit cannot be set. When charge-enable is on and a cell is under threshold during protection, both FET outputs are forced off.

Top module: `odp_guard`

## Requirements
- R1: After reset both FET outputs are low, `sleepOut` and `protMode` are low, and `serialEn` is high.
- R2: Outside protection, a cycle with `wrEn` high loads `wrChg` into the charge FET bit and `wrDis` into the discharge FET bit. The outputs follow from the next cycle.
- R3: Any high bit of `cellUnder` starts the detection timer, and `detActive` rises one cycle later. If all bits clear before `UV_DLY` ticks have passed, the timer is cancelled and no protection follows.
- R4: Suppose a cell is still under threshold when the detection timer expires, which is `UV_DLY` ticks after the start. Then both FETs go off, and `protMode` and `sleepOut` go high while `serialEn` goes low, all on the next cycle.
- R5: Sleep persists until `supplyWake` is high. On wake, sleep ends at once, but protection stays on for a hold-off of max(`OV_DLY`,`UV_DLY`)+`HOLD_DLY` ticks and for the rest of the recovery.
- R6: Host writes are discarded during sleep and during the hold-off window, including its last cycle.
- R7: After the hold-off, while still protected, a write sets the charge bit, but the discharge bit stays 0.
- R8: With `monitorMode` high, all `cellRecov` bits high start a release timer of `REL_DLY` ticks. If all bits are still high when it expires, normal mode returns. Any bit dropping first cancels the release.
- R9: With `monitorMode` low, recovery takes two samples `SMP_DLY` ticks apart. The second sample alone decides: if not all bits are high then, the block stays protected.
- R10: During protection, `chargeEnable` high together with any `cellUnder` bit forces both FET outputs low. The outputs come back when `chargeEnable` goes low.
- R11: Recovery leaves the charge FET bit unchanged and the discharge FET off until the host writes it. After recovery, a low `supplyWake` does not bring back sleep.
- R12: If a host write falls on the cycle that protection is entered, the protection clear wins and both FET bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow enable pulse for all timers |
| cellUnder | input | CELLS | Per-cell below over-discharge threshold |
| cellRecov | input | CELLS | Per-cell above recovery threshold |
| supplyWake | input | 1 | Supply above the sleep-return threshold |
| monitorMode | input | 1 | Monitor mode selected |
| chargeEnable | input | 1 | Cell charge-enable setting |
| wrEn | input | 1 | Host write strobe for the FET control bits |
| wrChg | input | 1 | Charge FET bit value to write |
| wrDis | input | 1 | Discharge FET bit value to write |
| chgFetOn | output | 1 | Charge FET gate enable |
| disFetOn | output | 1 | Discharge FET gate enable |
| sleepOut | output | 1 | Power-down request |
| serialEn | output | 1 | Serial port access enable |
| protMode | output | 1 | Over-discharge protection active |
| detActive | output | 1 | Detection timer running |
| relActive | output | 1 | Release timer or sample interval running |

## Verification
Two functions can land on the same edge: a host write of the FET bits and the expiry of the detection timer. The bench places a write of both bits at 1 exactly on the edge where protection is entered and expects both FETs off afterwards. A second collision sits at the end of the hold-off window, where the state leaves the window on the same edge that a host write is presented. The bench requires that this write is also lost, and that the very next write takes effect.

// File: rtl/odp_pkg.sv
package odp_pkg;
  typedef enum logic [1:0] {T_DET, T_REL, T_RST, T_SMP} timSel_e;

  typedef struct packed {
    logic    start;
    logic    stop;
    timSel_e sel;
  } timStb_t;

  typedef enum logic [2:0] {
    S_NORMAL, S_DETECT, S_SLEEP, S_RESET, S_WAIT, S_RELEASE, S_SAMPLE
  } odpState_e;
endpackage

// File: rtl/odp_timer.sv
module odp_timer
  import odp_pkg::*;
#(
  parameter int UV_DLY   = 6,
  parameter int OV_DLY   = 4,
  parameter int HOLD_DLY = 3,
  parameter int REL_DLY  = 5,
  parameter int SMP_DLY  = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  timStb_t stb,
  output logic    expired
);
  localparam int RST_DLY = ((OV_DLY > UV_DLY) ? OV_DLY : UV_DLY) + HOLD_DLY;
  localparam int MAX_A   = (UV_DLY > REL_DLY) ? UV_DLY : REL_DLY;
  localparam int MAX_B   = (RST_DLY > SMP_DLY) ? RST_DLY : SMP_DLY;
  localparam int MAX_DLY = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lenSel;
  logic             active;

  always_comb begin
    case (stb.sel)
      T_DET:   lenSel = CNT_W'(UV_DLY);
      T_REL:   lenSel = CNT_W'(REL_DLY);
      T_RST:   lenSel = CNT_W'(RST_DLY);
      default: lenSel = CNT_W'(SMP_DLY);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (stb.start) begin
      cnt    <= lenSel;
      active <= 1'b1;
    end else if (stb.stop) begin
      active <= 1'b0;
    end else if (active && tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = active && (cnt == '0);

  // R3: an expired timer stays expired until the control stops it
  p_hold_at_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (expired && !stb.start && !stb.stop) |=> expired);

  // R3: without a tick the count does not move
  p_tick_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (active && !tick && !stb.start && !stb.stop) |=> $stable(cnt));
endmodule

// File: rtl/odp_ctrl.sv
module odp_ctrl
  import odp_pkg::*;
#(
  parameter int CELLS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CELLS-1:0] cellUnder,
  input  logic [CELLS-1:0] cellRecov,
  input  logic             supplyWake,
  input  logic             monitorMode,
  input  logic             chargeEnable,
  input  logic             wrEn,
  input  logic             wrChg,
  input  logic             wrDis,
  input  logic             expired,
  output timStb_t          stb,
  output logic             chgFetOn,
  output logic             disFetOn,
  output logic             sleepOut,
  output logic             serialEn,
  output logic             protMode,
  output logic             detActive,
  output logic             relActive
);
  odpState_e state, nxt;
  logic chgReg, disReg, clearFet, anyUnder, allRecov, wrOk, disOk, hold;

  assign anyUnder = |cellUnder;
  assign allRecov = &cellRecov;

  always_comb begin
    nxt      = state;
    stb      = '{start: 1'b0, stop: 1'b0, sel: T_DET};
    clearFet = 1'b0;
    case (state)
      S_NORMAL: if (anyUnder) begin
        stb.start = 1'b1; stb.sel = T_DET; nxt = S_DETECT;
      end
      S_DETECT: if (!anyUnder) begin
        stb.stop = 1'b1; nxt = S_NORMAL;
      end else if (expired) begin
        stb.stop = 1'b1; clearFet = 1'b1; nxt = S_SLEEP;
      end
      S_SLEEP: if (supplyWake) begin
        stb.start = 1'b1; stb.sel = T_RST; nxt = S_RESET;
      end
      S_RESET: if (expired) begin
        stb.stop = 1'b1; nxt = S_WAIT;
      end
      S_WAIT: if (allRecov) begin
        stb.start = 1'b1;
        stb.sel   = monitorMode ? T_REL : T_SMP;
        nxt       = monitorMode ? S_RELEASE : S_SAMPLE;
      end
      S_RELEASE: if (!allRecov) begin
        stb.stop = 1'b1; nxt = S_WAIT;
      end else if (expired) begin
        stb.stop = 1'b1; nxt = S_NORMAL;
      end
      S_SAMPLE: if (expired) begin
        stb.stop = 1'b1; nxt = allRecov ? S_NORMAL : S_WAIT;
      end
      default: nxt = S_NORMAL;
    endcase
  end

  assign wrOk = (state != S_SLEEP) && (state != S_RESET);
  assign disOk = (state == S_NORMAL) || (state == S_DETECT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_NORMAL;
      chgReg <= 1'b0;
      disReg <= 1'b0;
    end else begin
      state <= nxt;
      if (clearFet) begin
        chgReg <= 1'b0;
        disReg <= 1'b0;
      end else if (wrEn) begin
        if (wrOk)  chgReg <= wrChg;
        if (disOk) disReg <= wrDis;
      end
    end
  end

  assign sleepOut  = (state == S_SLEEP);
  assign serialEn  = !sleepOut;
  assign protMode  = (state != S_NORMAL) && (state != S_DETECT);
  assign detActive = (state == S_DETECT);
  assign relActive = (state == S_RELEASE) || (state == S_SAMPLE);
  assign hold      = chargeEnable && anyUnder && protMode;
  assign chgFetOn  = chgReg && !hold;
  assign disFetOn  = disReg && !hold;

  p_sleep_fets_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    sleepOut |-> (!chgFetOn && !disFetOn));

  p_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    (detActive && anyUnder && expired) |=> (sleepOut && protMode));

  p_window_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SLEEP || state == S_RESET) |=> ($stable(chgReg) && $stable(disReg)));

  p_prot_dis_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    protMode |-> !disFetOn);

  p_charge_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (chargeEnable && anyUnder && protMode) |-> (!chgFetOn && !disFetOn));

  p_clear_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
    (detActive && anyUnder && expired) |=> (!chgReg && !disReg));
endmodule

// File: rtl/odp_guard.sv
module odp_guard
  import odp_pkg::*;
#(
  parameter int CELLS    = 3,
  parameter int UV_DLY   = 6,
  parameter int OV_DLY   = 4,
  parameter int HOLD_DLY = 3,
  parameter int REL_DLY  = 5,
  parameter int SMP_DLY  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [CELLS-1:0] cellUnder,
  input  logic [CELLS-1:0] cellRecov,
  input  logic             supplyWake,
  input  logic             monitorMode,
  input  logic             chargeEnable,
  input  logic             wrEn,
  input  logic             wrChg,
  input  logic             wrDis,
  output logic             chgFetOn,
  output logic             disFetOn,
  output logic             sleepOut,
  output logic             serialEn,
  output logic             protMode,
  output logic             detActive,
  output logic             relActive
);
  timStb_t stb;
  logic    expired;

  odp_ctrl #(.CELLS(CELLS)) uCtrl (
    .clk(clk), .rstN(rstN), .cellUnder(cellUnder), .cellRecov(cellRecov),
    .supplyWake(supplyWake), .monitorMode(monitorMode),
    .chargeEnable(chargeEnable), .wrEn(wrEn), .wrChg(wrChg), .wrDis(wrDis),
    .expired(expired), .stb(stb), .chgFetOn(chgFetOn), .disFetOn(disFetOn),
    .sleepOut(sleepOut), .serialEn(serialEn), .protMode(protMode),
    .detActive(detActive), .relActive(relActive)
  );

  odp_timer #(
    .UV_DLY(UV_DLY), .OV_DLY(OV_DLY), .HOLD_DLY(HOLD_DLY),
    .REL_DLY(REL_DLY), .SMP_DLY(SMP_DLY)
  ) uTimer (
    .clk(clk), .rstN(rstN), .tick(tick), .stb(stb), .expired(expired)
  );
endmodule

// File: tb/tb_odp_guard.sv
module tb_odp_guard;
  localparam int UV = 6, OV = 4, HOLD = 3, REL = 5, SMP = 4;
  localparam int RST_WIN = ((OV > UV) ? OV : UV) + HOLD;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b1;
  logic [2:0] cellUnder = '0, cellRecov = '0;
  logic supplyWake = 1'b0, monitorMode = 1'b0, chargeEnable = 1'b0;
  logic wrEn = 1'b0, wrChg = 1'b0, wrDis = 1'b0;
  logic chgFetOn, disFetOn, sleepOut, serialEn, protMode, detActive, relActive;
  int total = 0, failed = 0;

  always #4 clk = ~clk;

  odp_guard #(.CELLS(3), .UV_DLY(UV), .OV_DLY(OV), .HOLD_DLY(HOLD),
              .REL_DLY(REL), .SMP_DLY(SMP)) dut (.*);

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(logic c, logic d);
    wrEn = 1'b1; wrChg = c; wrDis = d;
    step(1);
    wrEn = 1'b0;
  endtask

  task automatic t_reset();
    step(3); rstN = 1'b1; step(1);
    chk("R1", "chg", chgFetOn, 1'b0);
    chk("R1", "dis", disFetOn, 1'b0);
    chk("R1", "sleep", sleepOut, 1'b0);
    chk("R1", "prot", protMode, 1'b0);
    chk("R1", "serial", serialEn, 1'b1);
  endtask

  task automatic t_write();
    hostWrite(1'b1, 1'b1);
    chk("R2", "chg on", chgFetOn, 1'b1);
    chk("R2", "dis on", disFetOn, 1'b1);
    hostWrite(1'b0, 1'b1);
    chk("R2", "chg off", chgFetOn, 1'b0);
    chk("R2", "dis kept", disFetOn, 1'b1);
    hostWrite(1'b1, 1'b1);
  endtask

  task automatic t_cancel();
    cellUnder = 3'b010; step(1);
    chk("R3", "det start", detActive, 1'b1);
    step(2); cellUnder = '0; step(1);
    chk("R3", "det cancel", detActive, 1'b0);
    step(UV + 4);
    chk("R3", "no sleep", sleepOut, 1'b0);
    chk("R3", "dis on", disFetOn, 1'b1);
  endtask

  task automatic t_enter();
    cellUnder = 3'b001;
    step(UV + 1);
    chk("R4", "not yet", sleepOut, 1'b0);
    chk("R4", "det running", detActive, 1'b1);
    hostWrite(1'b1, 1'b1); // lands on the entry edge
    chk("R4", "sleep", sleepOut, 1'b1);
    chk("R4", "serial off", serialEn, 1'b0);
    chk("R4", "prot", protMode, 1'b1);
    chk("R12", "chg cleared", chgFetOn, 1'b0);
    chk("R12", "dis cleared", disFetOn, 1'b0);
    step(5);
    chk("R5", "sleep persists", sleepOut, 1'b1);
    hostWrite(1'b1, 1'b1);
    chk("R6", "sleep write", chgFetOn, 1'b0);
  endtask

  task automatic t_wake();
    supplyWake = 1'b1; step(1);
    chk("R5", "awake", sleepOut, 1'b0);
    chk("R5", "serial", serialEn, 1'b1);
    chk("R5", "prot kept", protMode, 1'b1);
    hostWrite(1'b1, 1'b0);
    chk("R6", "window write", chgFetOn, 1'b0);
    step(RST_WIN - 2);
    hostWrite(1'b1, 1'b0);
    chk("R6", "late write", chgFetOn, 1'b0);
    hostWrite(1'b1, 1'b0); // same edge the window closes
    chk("R6", "last-edge write", chgFetOn, 1'b0);
    hostWrite(1'b1, 1'b1);
    chk("R7", "chg accepted", chgFetOn, 1'b1);
    chk("R7", "dis refused", disFetOn, 1'b0);
    chk("R7", "still prot", protMode, 1'b1);
  endtask

  task automatic t_hold();
    chargeEnable = 1'b1; step(1);
    chk("R10", "held off", chgFetOn, 1'b0);
    chargeEnable = 1'b0; step(1);
    chk("R10", "released", chgFetOn, 1'b1);
    cellUnder = '0; chargeEnable = 1'b1; step(1);
    chk("R10", "no under no hold", chgFetOn, 1'b1);
    chargeEnable = 1'b0;
  endtask

  task automatic t_monitor();
    monitorMode = 1'b1; cellRecov = 3'b111; step(1);
    chk("R8", "rel start", relActive, 1'b1);
    step(2); cellRecov = 3'b011; step(1);
    chk("R8", "rel cancel", relActive, 1'b0);
    step(REL + 3);
    chk("R8", "still prot", protMode, 1'b1);
    cellRecov = 3'b111;
    step(REL + 1);
    chk("R8", "not yet", protMode, 1'b1);
    step(1);
    chk("R8", "recovered", protMode, 1'b0);
    chk("R11", "chg unchanged", chgFetOn, 1'b1);
    chk("R11", "dis still off", disFetOn, 1'b0);
    supplyWake = 1'b0; step(3);
    chk("R11", "no resleep", sleepOut, 1'b0);
    chk("R11", "serial", serialEn, 1'b1);
    hostWrite(1'b1, 1'b1);
    chk("R11", "dis by host", disFetOn, 1'b1);
  endtask

  task automatic t_sample();
    cellRecov = '0; monitorMode = 1'b0; cellUnder = 3'b100;
    step(UV + 2);
    chk("R9", "reprotect", sleepOut, 1'b1);
    supplyWake = 1'b1; step(RST_WIN + 2);
    cellUnder = '0;
    cellRecov = 3'b111; step(1);
    chk("R9", "sample start", relActive, 1'b1);
    step(1); cellRecov = 3'b000; step(SMP);
    chk("R9", "second sample fails", protMode, 1'b1);
    chk("R9", "back to wait", relActive, 1'b0);
    cellRecov = 3'b111; step(2);
    cellRecov = 3'b110; step(1);
    cellRecov = 3'b111; step(SMP - 2);
    chk("R9", "not early", protMode, 1'b1);
    step(1);
    chk("R9", "two samples agree", protMode, 1'b0);
  endtask

  initial begin
    #1_000_000;
    total++; failed++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    t_reset();
    t_write();
    t_cancel();
    t_enter();
    t_wake();
    t_hold();
    t_monitor();
    t_sample();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule